// File: doc/BRIEF.md
# Dual-Clock Skew Error Detector

This block watches two slow clock-like signals that are meant to move in lockstep: a primary count clock and a redundant check clock. The watched event on the count clock is its rising edge, and the watched event on the check clock is its falling edge. Whichever of the two events arrives first opens a window. The partner event must then arrive within that window. Each direction has its own window length, given as a cycle count of the system clock. Any event left without a partner when its window closes is counted as one error.

Both watched signals are sampled by the system clock through a short synchronizer. Edges are detected after that synchronizer. A saturating counter holds the number of errors seen. Once that count reaches three, a sticky error flag goes high. The synchronous master reset clears the count, the flag and any open window. A detector-enable input covers the case where checking is not wanted. While it is low, no errors are counted and open windows are dropped.

A late partner does not close the window it was meant for. Instead it is treated as an unpaired event in the opposite direction. It opens its own window, and that window normally expires as well. A pair of edges skewed beyond the window therefore costs two errors.

Top module: `skew_watch`

## Requirements
- R1: A count-clock rising edge is matched, with no error, when a check-clock falling edge is seen d cycles later, where 0 <= d <= max(win_fwd,1) and d = 0 means the same sampled cycle. If no such edge arrives, exactly one error is counted.
- R2: A check-clock falling edge that does not match an open count window opens a reverse window. A count-clock rising edge within max(win_rev,1) cycles matches it, with no error. Otherwise exactly one error is counted. At most one window, forward or reverse, is open at any time.
- R3: win_fwd and win_rev act independently. A gap accepted in one direction can be rejected in the other.
- R4: A partner edge that arrives after its window has closed opens a window in the opposite direction. With no further edges, the pair costs two errors in total.
- R5: err_cnt reports the number of errors counted since reset as an unsigned binary value. It saturates at 3 and rises by at most one per cycle.
- R6: err_flag is low while err_cnt is below 3. It goes high once 3 errors have been counted, and it stays high until reset.
- R7: While rst is high, err_cnt becomes 0, err_flag becomes 0 and any open window is discarded. An edge in flight during reset produces no error afterwards.
- R8: While det_en is low, no error is counted and any open window is dropped. An unpaired edge seen while det_en is low, or a window open when det_en falls, never produces an error.
- R9: Falling edges of the count clock and rising edges of the check clock are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both watched signals |
| rst | input | 1 | Synchronous active-high master reset |
| det_en | input | 1 | Detector enable; low suppresses all error counting |
| cnt_clk_in | input | 1 | Primary count clock (rising edge watched) |
| chk_clk_in | input | 1 | Redundant check clock (falling edge watched) |
| win_fwd | input | WIN_W | Window in cycles for count-rise to check-fall (0 acts as 1) |
| win_rev | input | WIN_W | Window in cycles for check-fall to count-rise (0 acts as 1) |
| err_cnt | output | $clog2(ERR_LIMIT+1) | Saturating count of errors since reset |
| err_flag | output | 1 | Sticky flag, high once ERR_LIMIT errors were counted |

## Verification
A window tracker stuck open, or one that fails to open, shows on err_cnt as a missing or extra error. This appears within the window length plus the synchronizer depth and two more cycles after the edge that should have decided the outcome. A corrupted age counter moves the match boundary, so the stimulus places partner edges exactly on and one past each window length. An accumulator fault shows at once as err_flag disagreeing with err_cnt, or as a count passing 3 or stepping by more than one.

// File: rtl/sw_pkg.sv
package sw_pkg;

  // Which transition of a sampled signal an edge detector reports
  typedef enum logic {
    SW_EDGE_FALL = 1'b0,
    SW_EDGE_RISE = 1'b1
  } sw_pol_e;

  // Single-cycle edge events after synchronization
  typedef struct packed {
    logic chk_fall;
    logic cnt_rise;
  } sw_edges_t;

endpackage

// File: rtl/sw_edge_sync.sv
module sw_edge_sync #(
  parameter int              SYNC_STAGES = 2,
  parameter sw_pkg::sw_pol_e POL         = sw_pkg::SW_EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic pulse
);
  localparam int LAST = SYNC_STAGES;

  // chain[0] is the newest sample; chain[LAST] is one cycle older than chain[LAST-1]
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      // load the live level so that leaving reset creates no edge
      chain <= {(LAST + 1){sig_in}};
    end else begin
      chain <= {chain[LAST-1:0], sig_in};
    end
  end

  generate
    if (POL == sw_pkg::SW_EDGE_RISE) begin : g_rise
      assign pulse = chain[LAST-1] & ~chain[LAST];
    end else begin : g_fall
      assign pulse = ~chain[LAST-1] & chain[LAST];
    end
  endgenerate

  // R9: one sampled transition yields a one-cycle event
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/sw_skew_window.sv
module sw_skew_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             partner,
  input  logic [WIN_W-1:0] win,
  output logic             pending,
  output logic             err
);
  logic [WIN_W-1:0] age;
  logic             open_q;
  logic             expired;
  logic             reopen;

  // age counts cycles since the opening edge, starting at 1 one cycle later
  assign expired = (age >= win);
  assign reopen  = en & start & (open_q | ~partner);
  assign err     = en & open_q & ~partner & (start | expired);
  assign pending = open_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      open_q <= 1'b0;
      age    <= '0;
    end else if (reopen) begin
      open_q <= 1'b1;
      age    <= WIN_W'(1);
    end else if (open_q && (partner || expired)) begin
      open_q <= 1'b0;
      age    <= '0;
    end else if (open_q) begin
      age    <= age + WIN_W'(1);
    end
  end

  // R8: a disabled detector keeps no window open
  p_off_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pending);

  // R1: an open window always carries a started age
  p_age_started_r1: assert property (@(posedge clk) disable iff (rst)
    pending |-> (age != '0));

  // R1: an idle tracker reports no error
  p_err_needs_window_r1: assert property (@(posedge clk) disable iff (rst)
    !pending |-> !err);

endmodule

// File: rtl/sw_err_accum.sv
module sw_err_accum #(
  parameter int ERR_LIMIT = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              hit_a,
  input  logic                              hit_b,
  output logic [$clog2(ERR_LIMIT+1)-1:0]    err_cnt,
  output logic                              err_flag
);
  localparam int CW = $clog2(ERR_LIMIT + 1);

  logic [1:0]  hits;
  logic [CW:0] sum;
  logic [CW:0] limit_w;
  logic [CW-1:0] cnt_next;

  assign limit_w  = (CW + 1)'(ERR_LIMIT);
  assign hits     = {1'b0, hit_a} + {1'b0, hit_b};
  assign sum      = {1'b0, err_cnt} + (CW + 1)'(hits);
  assign cnt_next = (sum > limit_w) ? CW'(ERR_LIMIT) : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt  <= '0;
      err_flag <= 1'b0;
    end else begin
      err_cnt  <= cnt_next;
      err_flag <= err_flag | (sum >= limit_w);
    end
  end

  // R5: the count never passes its ceiling
  p_cnt_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= CW'(ERR_LIMIT));

  // R5: the count moves by zero or one per cycle
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + CW'(1)));

  // R6: the flag is sticky
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R6: the flag and the count agree
  p_flag_at_limit_r6: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_cnt == CW'(ERR_LIMIT)));

endmodule

// File: rtl/skew_watch.sv
module skew_watch #(
  parameter int WIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ERR_LIMIT   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           det_en,
  input  logic                           cnt_clk_in,
  input  logic                           chk_clk_in,
  input  logic [WIN_W-1:0]               win_fwd,
  input  logic [WIN_W-1:0]               win_rev,
  output logic [$clog2(ERR_LIMIT+1)-1:0] err_cnt,
  output logic                           err_flag
);
  import sw_pkg::*;

  localparam int NSIG = 2;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] evt;
  sw_edges_t       edg;

  assign raw = {chk_clk_in, cnt_clk_in};

  // lane 0 watches the count clock rising, lane 1 the check clock falling
  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_lane
      sw_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .POL         ((i == 0) ? SW_EDGE_RISE : SW_EDGE_FALL)
      ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_in (raw[i]),
        .pulse  (evt[i])
      );
    end
  endgenerate

  assign edg.cnt_rise = evt[0];
  assign edg.chk_fall = evt[1];

  logic pend_fwd, pend_rev;
  logic err_fwd, err_rev;
  logic start_fwd, start_rev;

  // an edge that answers the other direction's open window opens nothing;
  // simultaneous edges are settled by the forward tracker alone
  assign start_fwd = edg.cnt_rise & ~pend_rev;
  assign start_rev = edg.chk_fall & ~pend_fwd & ~edg.cnt_rise;

  sw_skew_window #(.WIN_W(WIN_W)) u_win_fwd (
    .clk     (clk),
    .rst     (rst),
    .en      (det_en),
    .start   (start_fwd),
    .partner (edg.chk_fall),
    .win     (win_fwd),
    .pending (pend_fwd),
    .err     (err_fwd)
  );

  sw_skew_window #(.WIN_W(WIN_W)) u_win_rev (
    .clk     (clk),
    .rst     (rst),
    .en      (det_en),
    .start   (start_rev),
    .partner (edg.cnt_rise),
    .win     (win_rev),
    .pending (pend_rev),
    .err     (err_rev)
  );

  sw_err_accum #(.ERR_LIMIT(ERR_LIMIT)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .hit_a    (err_fwd),
    .hit_b    (err_rev),
    .err_cnt  (err_cnt),
    .err_flag (err_flag)
  );

  // R2: the two directions never hold a window at the same time
  p_single_window_r2: assert property (@(posedge clk) disable iff (rst)
    !(pend_fwd && pend_rev));

  // R8: nothing is counted while the detector is disabled
  p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> $stable(err_cnt));

  // R7: the first cycle after reset starts from a clear state
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (err_cnt == '0) && !err_flag);

endmodule

// File: tb/skew_watch_bench.sv
module skew_watch_bench;
  localparam int WIN_W = 8;
  localparam int NVEC  = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       det_en = 1'b1;
  logic       cnt_in = 1'b0;
  logic       chk_in = 1'b1;
  logic [7:0] win_fwd = 8'd4;
  logic [7:0] win_rev = 8'd4;
  logic [1:0] err_cnt;
  logic       err_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  skew_watch #(.WIN_W(WIN_W), .SYNC_STAGES(2), .ERR_LIMIT(3)) u_skew_watch (
    .clk        (clk),
    .rst        (rst),
    .det_en     (det_en),
    .cnt_clk_in (cnt_in),
    .chk_clk_in (chk_in),
    .win_fwd    (win_fwd),
    .win_rev    (win_rev),
    .err_cnt    (err_cnt),
    .err_flag   (err_flag)
  );

  // {win_fwd, win_rev, order (0 count first, 1 check first), gap (FF none), req<<4 | errors}
  localparam logic [39:0] VECS [NVEC] = '{
    40'h04_04_00_00_10,  // R1 same sampled cycle
    40'h04_04_00_03_10,  // R1 inside window
    40'h04_04_00_04_10,  // R1 on the boundary
    40'h04_04_00_05_42,  // R4 one past boundary: two errors
    40'h04_04_01_04_20,  // R2 on the boundary
    40'h04_04_01_05_42,  // R4 reverse late partner
    40'h06_02_00_06_30,  // R3 long forward window accepts 6
    40'h06_02_01_03_32,  // R3 short reverse window rejects 3
    40'h06_02_01_02_30,  // R3 short reverse window accepts 2
    40'h00_00_00_01_10,  // R1 zero window acts as one
    40'h00_00_00_02_42,  // R4 zero window, gap 2
    40'h03_03_00_FF_11,  // R1 partner never comes
    40'h03_03_01_FF_21   // R2 partner never comes
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
  endtask

  task automatic orphan_rise();
    cnt_in = 1'b1;
    wait_n(20);
    cnt_in = 1'b0;
    wait_n(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R7 reset count", int'(err_cnt), 0);
    check("R7 reset flag", int'(err_flag), 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [39:0] e;
      int gap;
      string tag;
      e = VECS[v];
      gap = int'(e[15:8]);
      cnt_in = 1'b0;
      chk_in = 1'b1;
      win_fwd = e[39:32];
      win_rev = e[31:24];
      det_en = 1'b1;
      do_reset();
      if (e[16] == 1'b0) begin
        cnt_in = 1'b1;
        if (gap == 0) chk_in = 1'b0;
        else if (gap != 255) begin
          wait_n(gap);
          chk_in = 1'b0;
        end
      end else begin
        chk_in = 1'b0;
        if (gap == 0) cnt_in = 1'b1;
        else if (gap != 255) begin
          wait_n(gap);
          cnt_in = 1'b1;
        end
      end
      wait_n(30);
      cnt_in = 1'b0;
      chk_in = 1'b1;
      wait_n(30);
      tag = $sformatf("R%0d vector %0d", int'(e[7:4]), v);
      check(tag, int'(err_cnt), int'(e[3:0]));
    end

    win_fwd = 8'd4;
    win_rev = 8'd4;

    // R9: only ignored transitions
    cnt_in = 1'b1;
    chk_in = 1'b0;
    do_reset();
    cnt_in = 1'b0;
    chk_in = 1'b1;
    wait_n(30);
    check("R9 ignored edges", int'(err_cnt), 0);

    // R8: unpaired edges while disabled
    det_en = 1'b0;
    orphan_rise();
    orphan_rise();
    wait_n(5);
    check("R8 disabled count", int'(err_cnt), 0);
    det_en = 1'b1;
    wait_n(2);

    // R8: window open when disable arrives
    cnt_in = 1'b1;
    wait_n(4);
    det_en = 1'b0;
    wait_n(1);
    det_en = 1'b1;
    wait_n(20);
    cnt_in = 1'b0;
    wait_n(4);
    check("R8 dropped window", int'(err_cnt), 0);

    // R5/R6 accumulation
    orphan_rise();
    orphan_rise();
    check("R5 two errors", int'(err_cnt), 2);
    check("R6 flag below limit", int'(err_flag), 0);
    orphan_rise();
    check("R5 three errors", int'(err_cnt), 3);
    check("R6 flag at limit", int'(err_flag), 1);
    orphan_rise();
    check("R5 saturation", int'(err_cnt), 3);
    wait_n(50);
    check("R6 flag sticky", int'(err_flag), 1);

    // R7: reset clears everything
    do_reset();
    check("R7 clear count", int'(err_cnt), 0);
    check("R7 clear flag", int'(err_flag), 0);

    // R7: window in flight discarded by reset
    win_fwd = 8'd6;
    cnt_in = 1'b1;
    wait_n(4);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(20);
    check("R7 in-flight window", int'(err_cnt), 0);
    cnt_in = 1'b0;
    wait_n(4);

    done = 1'b1;
    summary();
  end

endmodule